// File: doc/BRIEF.md
# Trace Control Register Access Trap Checker

This block decides, in a single combinational step, what happens to one access to a trace control register. It looks at the exception level of the access, whether the access is a read or a write, and the core's debug and trap state. It then reports one of five outcomes: the access completes, it is undefined, or it traps to EL1, EL2 or EL3. When the outcome is a trap, it also gives the syndrome exception class the exception entry logic needs.

Reads and writes use the same system register encoding: op0=2, op1=1, CRn=0, CRm=8, op2=0. Instruction decode is therefore done upstream, and only `write_i` tells the two directions apart here. The checks run in a fixed priority order that is different at each exception level. While the core is halted with secure debug disabled, a trap to EL3 taken from EL1 or EL2 becomes undefined. The parameter `EarlyUndefEn` selects an implementation choice: when it is set, that EL3 condition is tested before every other check rather than in its own place in the order.

Top module: `tcr_access_trap_chk`

## Requirements
- R1: An access at EL0 (`el_i`=0) is undefined, whatever the other inputs are.
- R2: At EL1 the checks run in this order, and the first match wins: `trap_el1_i` traps to EL1; `trap_el2_i` with EL2 in effect traps to EL2; the fine-grained trap traps to EL2; `trap_el3_i` with EL3 present traps to EL3. If nothing matches, the access is allowed.
- R3: With `EarlyUndefEn`=1, an access at EL1 or EL2 is undefined before any other check when all of these hold: halted, secure debug disabled, EL3 present and `trap_el3_i` set. With `EarlyUndefEn`=0 this early test does not exist.
- R4: The fine-grained trap at EL1 needs EL2 in effect, and also needs either EL3 to be absent or `fg_enable_i` to be set. A read tests `fg_rd_trap_i` and a write tests `fg_wr_trap_i`; the bit for the other direction has no effect.
- R5: At EL2 the order is: `trap_el2_i` traps to EL2, then `trap_el3_i` with EL3 present traps to EL3, and otherwise the access is allowed. `trap_el1_i`, the fine-grained bits and `el2_enabled_i` have no effect at EL2.
- R6: At EL3 the outcome is a trap to EL3 when `trap_el3_i` is set and allowed otherwise. The halted flag and the secure-debug-disable flag do not change this outcome.
- R7: At EL1 or EL2, an access that would trap to EL3 while halted with secure debug disabled is undefined instead.
- R8: `ec_o` is 0x18 whenever the result is one of the three traps, and 0 otherwise.
- R9: `res_o` is exactly one-hot. Bit 0 means allow, bit 1 undefined, bit 2 trap to EL1, bit 3 trap to EL2 and bit 4 trap to EL3.
- R10: When `el2_present_i` is 0, `el2_enabled_i` is treated as 0.
- R11: When `el3_present_i` is 0, `trap_el3_i` has no effect at EL1 or EL2, and this includes the early test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| el_i | input | 2 | Exception level of the access (0 to 3) |
| write_i | input | 1 | 1 for a write, 0 for a read |
| halted_i | input | 1 | Core is in debug halt |
| dbg_lock_i | input | 1 | Secure debug is disabled |
| el2_present_i | input | 1 | EL2 is implemented |
| el3_present_i | input | 1 | EL3 is implemented |
| el2_enabled_i | input | 1 | EL2 is enabled in the current state |
| trap_el1_i | input | 1 | Trap control bit owned by EL1 |
| trap_el2_i | input | 1 | Trap control bit owned by EL2 |
| trap_el3_i | input | 1 | Trap control bit owned by EL3 |
| fg_enable_i | input | 1 | EL3 enables fine-grained traps |
| fg_rd_trap_i | input | 1 | Fine-grained trap bit for reads |
| fg_wr_trap_i | input | 1 | Fine-grained trap bit for writes |
| res_o | output | 5 | One-hot outcome |
| ec_o | output | 6 | Syndrome exception class for a trap |

## Verification
The bench builds two copies of the block side by side, one with `EarlyUndefEn`=1 and one with `EarlyUndefEn`=0, and drives both with the same vectors. In some of those vectors the EL1 or EL2 trap bit competes with the halted, secure-debug-disabled EL3 condition. The two copies give different answers only there, so a single vector shows both where the early test sits in the order and that it is missing when the parameter is 0. The other vectors cover the order at each exception level, the choice of fine-grained bit by direction, and the cases where EL2 or EL3 is absent. In all of these the two copies must agree.

// File: rtl/tcr_trap_pkg.sv
package tcr_trap_pkg;

  localparam int unsigned ResW = 5;
  localparam int unsigned EcW  = 6;
  localparam logic [EcW-1:0] EcTrap = 6'h18;

  typedef enum logic [ResW-1:0] {
    RES_ALLOW = 5'b00001,
    RES_UNDEF = 5'b00010,
    RES_TRAP1 = 5'b00100,
    RES_TRAP2 = 5'b01000,
    RES_TRAP3 = 5'b10000
  } acc_res_e;

  // EL3 trap seen from a lower level: halted with secure debug off -> undefined
  function automatic acc_res_e el3_outcome(input logic locked_halt);
    return locked_halt ? RES_UNDEF : RES_TRAP3;
  endfunction

endpackage

// File: rtl/tcr_trap_early.sv
module tcr_trap_early #(
  parameter bit EarlyUndefEn = 1'b1
) (
  input  logic halted_i,
  input  logic dbg_lock_i,
  input  logic el3_present_i,
  input  logic trap_el3_i,
  output logic early_undef_o
);

  generate
    if (EarlyUndefEn) begin : g_early
      assign early_undef_o = halted_i & dbg_lock_i & el3_present_i & trap_el3_i;
    end else begin : g_none
      logic unused_w;
      assign unused_w      = halted_i ^ dbg_lock_i ^ el3_present_i ^ trap_el3_i;
      assign early_undef_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/tcr_trap_el1.sv
module tcr_trap_el1
  import tcr_trap_pkg::*;
(
  input  logic     early_undef_i,
  input  logic     locked_halt_i,
  input  logic     el2_eff_i,
  input  logic     el3_present_i,
  input  logic     trap_el1_i,
  input  logic     trap_el2_i,
  input  logic     trap_el3_i,
  input  logic     fg_enable_i,
  input  logic     fg_bit_i,
  output acc_res_e res_o
);

  logic fg_hit;
  assign fg_hit = el2_eff_i & (~el3_present_i | fg_enable_i) & fg_bit_i;

  always_comb begin
    if (early_undef_i)                   res_o = RES_UNDEF;
    else if (trap_el1_i)                 res_o = RES_TRAP1;
    else if (el2_eff_i && trap_el2_i)    res_o = RES_TRAP2;
    else if (fg_hit)                     res_o = RES_TRAP2;
    else if (el3_present_i && trap_el3_i) res_o = el3_outcome(locked_halt_i);
    else                                 res_o = RES_ALLOW;
  end

  // R10
  always_comb begin
    el2_gate_chk: assert (el2_eff_i || res_o != RES_TRAP2)
      else $error("EL1 trap to EL2 with EL2 not in effect");
  end

endmodule

// File: rtl/tcr_trap_el2.sv
module tcr_trap_el2
  import tcr_trap_pkg::*;
(
  input  logic     early_undef_i,
  input  logic     locked_halt_i,
  input  logic     el3_present_i,
  input  logic     trap_el2_i,
  input  logic     trap_el3_i,
  output acc_res_e res_o
);

  always_comb begin
    if (early_undef_i)                    res_o = RES_UNDEF;
    else if (trap_el2_i)                  res_o = RES_TRAP2;
    else if (el3_present_i && trap_el3_i) res_o = el3_outcome(locked_halt_i);
    else                                  res_o = RES_ALLOW;
  end

  // R5
  always_comb begin
    no_trap1_chk: assert (res_o != RES_TRAP1)
      else $error("EL2 access routed to EL1");
  end

endmodule

// File: rtl/tcr_access_trap_chk.sv
module tcr_access_trap_chk
  import tcr_trap_pkg::*;
#(
  parameter bit EarlyUndefEn = 1'b1
) (
  input  logic [1:0]     el_i,
  input  logic           write_i,
  input  logic           halted_i,
  input  logic           dbg_lock_i,
  input  logic           el2_present_i,
  input  logic           el3_present_i,
  input  logic           el2_enabled_i,
  input  logic           trap_el1_i,
  input  logic           trap_el2_i,
  input  logic           trap_el3_i,
  input  logic           fg_enable_i,
  input  logic           fg_rd_trap_i,
  input  logic           fg_wr_trap_i,
  output logic [ResW-1:0] res_o,
  output logic [EcW-1:0]  ec_o
);

  logic     el2_eff, locked_halt, early_undef, fg_bit;
  acc_res_e res_el1, res_el2, res_sel;

  assign el2_eff     = el2_present_i & el2_enabled_i;
  assign locked_halt = halted_i & dbg_lock_i;
  assign fg_bit      = write_i ? fg_wr_trap_i : fg_rd_trap_i;

  tcr_trap_early #(.EarlyUndefEn(EarlyUndefEn)) i_early (
    .halted_i      (halted_i),
    .dbg_lock_i    (dbg_lock_i),
    .el3_present_i (el3_present_i),
    .trap_el3_i    (trap_el3_i),
    .early_undef_o (early_undef)
  );

  tcr_trap_el1 i_el1 (
    .early_undef_i (early_undef),
    .locked_halt_i (locked_halt),
    .el2_eff_i     (el2_eff),
    .el3_present_i (el3_present_i),
    .trap_el1_i    (trap_el1_i),
    .trap_el2_i    (trap_el2_i),
    .trap_el3_i    (trap_el3_i),
    .fg_enable_i   (fg_enable_i),
    .fg_bit_i      (fg_bit),
    .res_o         (res_el1)
  );

  tcr_trap_el2 i_el2 (
    .early_undef_i (early_undef),
    .locked_halt_i (locked_halt),
    .el3_present_i (el3_present_i),
    .trap_el2_i    (trap_el2_i),
    .trap_el3_i    (trap_el3_i),
    .res_o         (res_el2)
  );

  always_comb begin
    unique case (el_i)
      2'd0:    res_sel = RES_UNDEF;
      2'd1:    res_sel = res_el1;
      2'd2:    res_sel = res_el2;
      default: res_sel = trap_el3_i ? RES_TRAP3 : RES_ALLOW;
    endcase
  end

  assign res_o = res_sel;
  assign ec_o  = (res_sel inside {RES_TRAP1, RES_TRAP2, RES_TRAP3}) ? EcTrap : '0;

  // R9
  always_comb begin
    onehot_chk: assert ($countones(res_o) == 1)
      else $error("result not one-hot");
  end

  // R8
  always_comb begin
    ec_zero_chk: assert ((res_o[2] | res_o[3] | res_o[4]) || ec_o == '0)
      else $error("syndrome set without trap");
  end

  // R1
  always_comb begin
    el0_undef_chk: assert (el_i != 2'd0 || res_o == RES_UNDEF)
      else $error("EL0 access not undefined");
  end

  // R6
  always_comb begin
    el3_only_chk: assert (el_i != 2'd3 || res_o == RES_ALLOW || res_o == RES_TRAP3)
      else $error("EL3 access with foreign outcome");
  end

  // R11
  always_comb begin
    no_el3_chk: assert (el3_present_i || el_i == 2'd3 || res_o != RES_TRAP3)
      else $error("trap to absent EL3");
  end

endmodule

// File: tb/test_tcr_access_trap_chk.sv
module test_tcr_access_trap_chk;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] el;
  logic wr, halt, lock, h2, h3, e2, t1, t2, t3, fge, fgr, fgw;
  logic [4:0] res_e, res_l;
  logic [5:0] ec_e, ec_l;

  localparam logic [4:0] A = 5'b00001, U = 5'b00010, T1 = 5'b00100,
                         T2 = 5'b01000, T3 = 5'b10000;

  tcr_access_trap_chk #(.EarlyUndefEn(1'b1)) i_tcr_access_trap_chk (
    .el_i(el), .write_i(wr), .halted_i(halt), .dbg_lock_i(lock),
    .el2_present_i(h2), .el3_present_i(h3), .el2_enabled_i(e2),
    .trap_el1_i(t1), .trap_el2_i(t2), .trap_el3_i(t3),
    .fg_enable_i(fge), .fg_rd_trap_i(fgr), .fg_wr_trap_i(fgw),
    .res_o(res_e), .ec_o(ec_e)
  );

  tcr_access_trap_chk #(.EarlyUndefEn(1'b0)) i_tcr_access_trap_chk_late (
    .el_i(el), .write_i(wr), .halted_i(halt), .dbg_lock_i(lock),
    .el2_present_i(h2), .el3_present_i(h3), .el2_enabled_i(e2),
    .trap_el1_i(t1), .trap_el2_i(t2), .trap_el3_i(t3),
    .fg_enable_i(fge), .fg_rd_trap_i(fgr), .fg_wr_trap_i(fgw),
    .res_o(res_l), .ec_o(ec_l)
  );

  typedef struct {
    logic [4:0] exp_e;
    logic [4:0] exp_l;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  function automatic logic [5:0] exp_ec(input logic [4:0] r);
    return (r == T1 || r == T2 || r == T3) ? 6'h18 : 6'h00;
  endfunction

  task automatic drive(input logic [1:0] e_l, input logic w, input logic h,
                       input logic lk, input logic p2, input logic p3,
                       input logic n2, input logic b1, input logic b2,
                       input logic b3, input logic fe, input logic fr,
                       input logic fw, input logic [4:0] xe,
                       input logic [4:0] xl, input string tag);
    exp_t it;
    @(posedge clk);
    #1;
    el = e_l; wr = w; halt = h; lock = lk; h2 = p2; h3 = p3; e2 = n2;
    t1 = b1; t2 = b2; t3 = b3; fge = fe; fgr = fr; fgw = fw;
    it.exp_e = xe; it.exp_l = xl; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cmp(input string who, input string tag, input logic [4:0] r,
                     input logic [5:0] ec, input logic [4:0] x);
    total++;
    if (r !== x || ec !== exp_ec(x)) begin
      bad++;
      $display("FAIL %s %s: res=%b ec=%h expected res=%b ec=%h",
               tag, who, r, ec, x, exp_ec(x));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      cmp("early", it.tag, res_e, ec_e, it.exp_e);
      cmp("late",  it.tag, res_l, ec_l, it.exp_l);
    end
  end

  // driver; argument order: el wr halt lock h2 h3 e2 t1 t2 t3 fge fgr fgw
  initial begin
    el = 2'd0; {wr, halt, lock, h2, h3, e2, t1, t2, t3, fge, fgr, fgw} = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, U,  U,  "R1 idle");
    drive(0, 1, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, U,  U,  "R1 all traps");
    drive(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, A,  A,  "R2 allow");
    drive(1, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0, 0, 0, T1, T1, "R2 el1 first");
    drive(1, 1, 0, 0, 1, 1, 1, 0, 1, 1, 0, 0, 0, T2, T2, "R2 el2 second");
    drive(1, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, T3, T3, "R2 el3 last");
    drive(1, 0, 0, 0, 1, 1, 1, 0, 0, 1, 1, 1, 0, T2, T2, "R4 read fg before el3");
    drive(1, 1, 0, 0, 1, 1, 1, 0, 0, 0, 1, 1, 0, A,  A,  "R4 write ignores rd bit");
    drive(1, 1, 0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 1, T2, T2, "R4 write fg");
    drive(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 1, A,  A,  "R4 read ignores wr bit");
    drive(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 1, 1, A,  A,  "R4 fg disabled by el3");
    drive(1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 1, 0, T2, T2, "R4 fg no el3");
    drive(1, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 1, 1, A,  A,  "R10 el2 absent");
    drive(1, 0, 0, 0, 1, 1, 0, 0, 1, 0, 1, 1, 1, A,  A,  "R10 el2 disabled");
    drive(1, 0, 0, 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, A,  A,  "R11 el3 absent");
    drive(1, 0, 1, 1, 1, 0, 1, 1, 0, 1, 0, 0, 0, T1, T1, "R11 no early without el3");
    drive(1, 0, 1, 1, 1, 1, 1, 1, 0, 1, 0, 0, 0, U,  T1, "R3 el1 early undef");
    drive(1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 0, 0, 0, U,  U,  "R7 el1 locked halt");
    drive(1, 0, 1, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0, T3, T3, "R7 halt without lock");
    drive(2, 0, 1, 1, 1, 1, 1, 0, 1, 1, 0, 0, 0, U,  T2, "R3 el2 early undef");
    drive(2, 0, 0, 0, 1, 1, 0, 0, 1, 1, 0, 0, 0, T2, T2, "R5 el2 trap");
    drive(2, 1, 0, 0, 1, 1, 1, 1, 0, 0, 1, 1, 1, A,  A,  "R5 el1 and fg ignored");
    drive(2, 0, 0, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0, T3, T3, "R5 el3 trap");
    drive(2, 1, 1, 1, 1, 1, 1, 0, 0, 1, 0, 0, 0, U,  U,  "R7 el2 locked halt");
    drive(3, 0, 0, 0, 1, 1, 1, 0, 0, 1, 0, 0, 0, T3, T3, "R6 el3 trap");
    drive(3, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1, A,  A,  "R6 el3 allow");
    drive(3, 0, 1, 1, 1, 1, 1, 0, 0, 1, 0, 0, 0, T3, T3, "R6 no halt override");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 10000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    if (q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule